// File: doc/BRIEF.md
# Fault Ride-Through Power Reference Controller

This block sits between grid-voltage sensing and the power regulator of a battery-to-grid converter. It takes one signed grid-voltage sample per switching period (20.4 kHz, so 340 samples per 60 Hz cycle). From each sample and the sample taken 85 periods earlier, a quarter cycle back, it forms the instantaneous peak amplitude. It then sorts the retained voltage into one of three bands: normal, moderate dip or severe dip.

The band decides what goes to the downstream regulator and switch drivers. In the normal band the power reference follows a saturated command. A moderate dip first forces a fixed phase shift for 50 ms and then scales the reference with the measured peak, so that inverter current stays within its limit. A severe dip blanks the gates of both the inverter and the DC-DC bridges. The reference in effect before the dip is kept and is restored by a linear 10 ms ramp once the voltage returns.

Voltage samples carry 0.5 V per LSB. The 40 % threshold (115 V peak) is code 230 and the 20 % threshold (57.5 V) is code 115. Power is in watts, rated 6000.

Top module: `frt_pref_ctrl`

## Requirements
- R1: On each strobe the peak is floor(sqrt(v² + vd²)), where vd is the sample taken 85 strobes earlier (zero after reset). A peak of 230 or more is the normal band, 115 to 229 is moderate, and below 115 is severe.
- R2: A band is accepted only when two consecutive strobes show it. A single-strobe excursion changes no output.
- R3: In normal mode (mode code 0) the reference is min(command, 6000), the gates are on and the phase-shift override is invalid. The reference never exceeds 6000.
- R4: Accepting the moderate band from normal or recovering mode enters hold mode (code 1). Hold mode holds the reference at min(1200, latched value) and drives the override valid with value 9830 (0.15 of 16-bit full scale) for 1020 strobes.
- R5: After the hold, scaling mode (code 2) sets the reference to min(floor(6000·peak/230), latched value) on every strobe.
- R6: Accepting the severe band enters blanking mode (code 3) on the same strobe from any mode. Blanking mode sets the reference to 0, turns both gate enables off and drives the override valid with value 0.
- R7: In blanking mode, the gates come back on after 340 consecutive strobes with peak ≥ 115. The block then goes to recovering mode if the accepted band is normal, and to hold mode otherwise.
- R8: Leaving a normal-band dip enters recovering mode (code 4). With start value s and latched target t, the reference on the k-th strobe is s + floor((t−s)·k/204) for k = 1..204. At k = 204 the block returns to normal mode. The target t is the reference latched when normal mode was last left.
- R9: After reset the block is in blanking mode, with reference 0, gates off, override valid with value 0, latched target 6000, and the severe band accepted.
- R10: Outputs change only on the clock edge that samples a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | One-cycle strobe per switching period |
| v_smp_i | input | 12 | Signed grid-voltage sample, 0.5 V per LSB |
| p_cmd_i | input | 13 | Requested power reference in watts |
| p_ref_o | output | 13 | Power reference to the regulator in watts |
| ps_ovr_o | output | 16 | Phase-shift override value |
| ps_ovr_valid_o | output | 1 | Override replaces the regulator output |
| inv_gate_en_o | output | 1 | Inverter gate enable |
| dcdc_gate_en_o | output | 1 | DC-DC bridge gate enable |
| mode_o | output | 3 | Mode code (0 normal, 1 hold, 2 scale, 3 blank, 4 recover) |

## Verification
A faulty delay tap or square root shows up as a band decision at the wrong amplitude. In scaling mode it also shows as a reference that differs on the very next strobe. A wrong hold, good-cycle or ramp counter only becomes visible at the end of its window, up to 1020 strobes later. For that reason the bench compares every port on every strobe over whole dips, not only at their edges. A stale latched target stays hidden until the last ramp step, where the reference settles on the wrong value.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    BND_NORM = 2'd0,
    BND_MOD  = 2'd1,
    BND_SEV  = 2'd2
  } band_e;

  typedef enum logic [2:0] {
    MD_NORMAL  = 3'd0,
    MD_HOLD    = 3'd1,
    MD_SCALE   = 3'd2,
    MD_BLANK   = 3'd3,
    MD_RECOVER = 3'd4
  } mode_e;
endpackage

// File: rtl/frt_qdelay.sv
module frt_qdelay #(
  parameter int W     = 12,
  parameter int DEPTH = 85
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] q_o
);
  logic signed [W-1:0] tap [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else if (en_i) begin
      for (int i = DEPTH - 1; i > 0; i--) tap[i] <= tap[i-1];
      tap[0] <= d_i;
    end
  end

  assign q_o = tap[DEPTH-1];
endmodule

// File: rtl/frt_peak.sv
module frt_peak #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic        [W-1:0] peak_o
);
  localparam int SW = 2 * W + 1;

  logic [W-1:0]  mag_a, mag_b, cand;
  logic [SW-1:0] sum;

  // unsigned view of the negated value is exact, including the most negative code
  assign mag_a = a_i[W-1] ? W'(-a_i) : W'(a_i);
  assign mag_b = b_i[W-1] ? W'(-b_i) : W'(b_i);
  assign sum   = SW'(mag_a) * SW'(mag_a) + SW'(mag_b) * SW'(mag_b);

  // bitwise root: keep each bit whose square stays within the sum
  always_comb begin
    peak_o = '0;
    cand   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      cand = peak_o | (W'(1) << i);
      if (SW'(cand) * SW'(cand) <= sum) peak_o = cand;
    end
  end
endmodule

// File: rtl/frt_band.sv
module frt_band
  import frt_pkg::*;
#(
  parameter int PW    = 12,
  parameter int TH_HI = 230,
  parameter int TH_LO = 115
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] peak_i,
  output band_e         raw_o,
  output band_e         acc_nx_o
);
  band_e prev_q, acc_q;

  always_comb begin
    if (peak_i >= PW'(TH_HI))      raw_o = BND_NORM;
    else if (peak_i >= PW'(TH_LO)) raw_o = BND_MOD;
    else                           raw_o = BND_SEV;
  end

  assign acc_nx_o = (en_i && raw_o == prev_q) ? raw_o : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= BND_SEV;
      acc_q  <= BND_SEV;
    end else if (en_i) begin
      prev_q <= raw_o;
      acc_q  <= acc_nx_o;
    end
  end

  AST_DEB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && raw_o != prev_q) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/frt_pref_ctrl.sv
module frt_pref_ctrl
  import frt_pkg::*;
#(
  parameter int VW      = 12,
  parameter int PWR_W   = 13,
  parameter int PS_W    = 16,
  parameter int QDLY    = 85,
  parameter int CYC_N   = 340,
  parameter int HOLD_N  = 1020,
  parameter int RAMP_N  = 204,
  parameter int TH_HI   = 230,
  parameter int TH_LO   = 115,
  parameter int P_RATED = 6000,
  parameter int PS_HOLD = 9830
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic signed [VW-1:0] v_smp_i,
  input  logic [PWR_W-1:0]     p_cmd_i,
  output logic [PWR_W-1:0]     p_ref_o,
  output logic [PS_W-1:0]      ps_ovr_o,
  output logic                 ps_ovr_valid_o,
  output logic                 inv_gate_en_o,
  output logic                 dcdc_gate_en_o,
  output logic [2:0]           mode_o
);
  localparam int HOLD_W = $clog2(HOLD_N);
  localparam int OK_W   = $clog2(CYC_N);
  localparam int K_W    = $clog2(RAMP_N + 1);
  localparam int P_HOLD = P_RATED / 5;

  logic signed [VW-1:0] v_dly;
  logic [VW-1:0]        peak;
  band_e                raw, acc_nx;

  frt_qdelay #(.W(VW), .DEPTH(QDLY)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i), .d_i(v_smp_i), .q_o(v_dly)
  );

  frt_peak #(.W(VW)) u_peak (.a_i(v_smp_i), .b_i(v_dly), .peak_o(peak));

  frt_band #(.PW(VW), .TH_HI(TH_HI), .TH_LO(TH_LO)) u_band (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i), .peak_i(peak),
    .raw_o(raw), .acc_nx_o(acc_nx)
  );

  mode_e              mode_q, mode_d;
  logic               gate_q, gate_d;
  logic [PWR_W-1:0]   pref_q, pref_d, latch_q, latch_d, s_q, s_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic [OK_W-1:0]    ok_q, ok_d;
  logic [K_W-1:0]     k_q, k_d;
  logic [PWR_W-1:0]   p_cmd_sat, p_scale, p_hold;
  logic [31:0]        scaled;

  function automatic logic [PWR_W-1:0] f_min(input logic [31:0] a, input logic [31:0] b);
    return PWR_W'((a < b) ? a : b);
  endfunction

  function automatic logic [PWR_W-1:0] f_ramp(input logic [PWR_W-1:0] s,
                                               input logic [PWR_W-1:0] t,
                                               input logic [K_W-1:0]   k);
    return PWR_W'(32'(s) + ((32'(t) - 32'(s)) * 32'(k)) / 32'(RAMP_N));
  endfunction

  assign p_cmd_sat = f_min(32'(p_cmd_i), 32'(P_RATED));
  assign scaled    = (32'(P_RATED) * 32'(peak)) / 32'(TH_HI);
  assign p_scale   = f_min(scaled, 32'(latch_q));
  assign p_hold    = f_min(32'(P_HOLD), 32'(latch_q));

  always_comb begin
    mode_d = mode_q; gate_d = gate_q; pref_d = pref_q; latch_d = latch_q;
    hold_d = hold_q; ok_d = ok_q; k_d = k_q; s_d = s_q;
    if (smp_valid_i) begin
      if (acc_nx == BND_SEV && mode_q != MD_BLANK) begin
        // severe band overrides every other mode on the confirming strobe
        mode_d = MD_BLANK; gate_d = 1'b0; pref_d = '0; ok_d = '0;
        if (mode_q == MD_NORMAL) latch_d = pref_q;
      end else begin
        unique case (mode_q)
          MD_NORMAL: begin
            if (acc_nx == BND_MOD) begin
              mode_d = MD_HOLD; latch_d = pref_q; hold_d = '0;
              pref_d = f_min(32'(P_HOLD), 32'(pref_q));
            end else pref_d = p_cmd_sat;
          end
          MD_HOLD: begin
            if (acc_nx == BND_NORM) begin
              mode_d = MD_RECOVER; s_d = pref_q; k_d = K_W'(1);
              pref_d = f_ramp(pref_q, latch_q, K_W'(1));
            end else if (hold_q == HOLD_W'(HOLD_N - 1)) begin
              mode_d = MD_SCALE; pref_d = p_scale;
            end else hold_d = hold_q + 1'b1;
          end
          MD_SCALE: begin
            if (acc_nx == BND_NORM) begin
              mode_d = MD_RECOVER; s_d = pref_q; k_d = K_W'(1);
              pref_d = f_ramp(pref_q, latch_q, K_W'(1));
            end else pref_d = p_scale;
          end
          MD_RECOVER: begin
            if (acc_nx == BND_MOD) begin
              mode_d = MD_HOLD; hold_d = '0; pref_d = p_hold;
            end else begin
              k_d    = k_q + 1'b1;
              pref_d = f_ramp(s_q, latch_q, k_q + 1'b1);
              if (k_q + 1'b1 == K_W'(RAMP_N)) mode_d = MD_NORMAL;
            end
          end
          MD_BLANK: begin
            if (raw != BND_SEV) begin
              if (ok_q == OK_W'(CYC_N - 1)) begin
                gate_d = 1'b1; ok_d = '0;
                if (acc_nx == BND_NORM) begin
                  mode_d = MD_RECOVER; s_d = pref_q; k_d = K_W'(1);
                  pref_d = f_ramp(pref_q, latch_q, K_W'(1));
                end else begin
                  mode_d = MD_HOLD; hold_d = '0; pref_d = p_hold;
                end
              end else ok_d = ok_q + 1'b1;
            end else ok_d = '0;
          end
          default: mode_d = MD_BLANK;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_BLANK; gate_q <= 1'b0; pref_q <= '0; latch_q <= PWR_W'(P_RATED);
      hold_q <= '0; ok_q <= '0; k_q <= '0; s_q <= '0;
    end else begin
      mode_q <= mode_d; gate_q <= gate_d; pref_q <= pref_d; latch_q <= latch_d;
      hold_q <= hold_d; ok_q <= ok_d; k_q <= k_d; s_q <= s_d;
    end
  end

  assign p_ref_o        = pref_q;
  assign mode_o         = mode_q;
  assign inv_gate_en_o  = gate_q;
  assign dcdc_gate_en_o = gate_q;
  assign ps_ovr_valid_o = (mode_q == MD_HOLD) || (mode_q == MD_BLANK);
  assign ps_ovr_o       = (mode_q == MD_HOLD) ? PS_W'(PS_HOLD) : '0;

  AST_REF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ref_o <= PWR_W'(P_RATED)); // R3
  AST_SEV_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && acc_nx == BND_SEV) |=> mode_o == 3'(MD_BLANK)); // R6
  AST_BLANK_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'(MD_BLANK) |-> (!inv_gate_en_o && p_ref_o == '0)); // R6
  AST_GATE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 3'(MD_BLANK) |-> inv_gate_en_o); // R7
  AST_RAMP_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MD_RECOVER) && $past(mode_o) == 3'(MD_RECOVER)) |-> p_ref_o >= $past(p_ref_o)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(smp_valid_i) |-> ($stable(p_ref_o) && $stable(mode_o) && $stable(inv_gate_en_o))); // R10
endmodule

// File: tb/sim_frt_pref_ctrl.sv
module sim_frt_pref_ctrl;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [11:0] v_smp = '0;
  logic [12:0]        p_cmd = '0;
  logic [12:0]        p_ref;
  logic [15:0]        ps_ovr;
  logic               ps_ovr_valid, inv_gate, dcdc_gate;
  logic [2:0]         mode;

  frt_pref_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .v_smp_i(v_smp),
    .p_cmd_i(p_cmd), .p_ref_o(p_ref), .ps_ovr_o(ps_ovr), .ps_ovr_valid_o(ps_ovr_valid),
    .inv_gate_en_o(inv_gate), .dcdc_gate_en_o(dcdc_gate), .mode_o(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int mode; int pref; int gate; int psv; int ps; string tag; } exp_t;
  exp_t sb_q[$];
  int n_cmp = 0, n_bad = 0, n_smp = 0;
  bit done = 0;

  // reference model state
  int dq[$];
  int m_prev = 2, m_acc = 2, m_mode = 3, m_gate = 0, m_pref = 0, m_latch = 6000;
  int m_hold = 0, m_ok = 0, m_k = 0, m_s = 0;
  string tag_now = "R9";

  function automatic int isqrt_ref(int x);
    int r = int'($sqrt(real'(x)));
    while (r * r > x) r--;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic start_ramp();
    m_mode = 4; m_s = m_pref; m_k = 1;
    m_pref = m_s + (m_latch - m_s) / 204;
  endtask

  task automatic enter_hold();
    m_mode = 1; m_hold = 0; m_pref = imin(1200, m_latch);
  endtask

  task automatic model_step(input int v);
    int vd, pk, raw, accn, sc;
    vd = dq[0]; void'(dq.pop_front()); dq.push_back(v);
    pk = isqrt_ref(v * v + vd * vd);                       // R1
    raw = (pk >= 230) ? 0 : (pk >= 115) ? 1 : 2;
    accn = (raw == m_prev) ? raw : m_acc;                   // R2
    m_prev = raw; m_acc = accn;
    sc = imin(6000 * pk / 230, m_latch);                    // R5
    if (accn == 2 && m_mode != 3) begin                     // R6
      if (m_mode == 0) m_latch = m_pref;
      m_mode = 3; m_gate = 0; m_pref = 0; m_ok = 0;
    end else begin
      case (m_mode)
        0: if (accn == 1) begin m_latch = m_pref; enter_hold(); end
           else m_pref = imin(int'(p_cmd), 6000);           // R3
        1: if (accn == 0) start_ramp();
           else if (m_hold == 1019) begin m_mode = 2; m_pref = sc; end
           else m_hold++;                                   // R4
        2: if (accn == 0) start_ramp(); else m_pref = sc;
        4: if (accn == 1) enter_hold();
           else begin                                       // R8
             m_k++; m_pref = m_s + ((m_latch - m_s) * m_k) / 204;
             if (m_k == 204) m_mode = 0;
           end
        default: if (raw != 2) begin                        // R7
             if (m_ok == 339) begin
               m_gate = 1; m_ok = 0;
               if (accn == 0) start_ramp(); else enter_hold();
             end else m_ok++;
           end else m_ok = 0;
      endcase
    end
  endtask

  task automatic check(input exp_t e, input string tag);
    n_cmp++;
    if (int'(mode) != e.mode || int'(p_ref) != e.pref || int'(inv_gate) != e.gate ||
        int'(dcdc_gate) != e.gate || int'(ps_ovr_valid) != e.psv || int'(ps_ovr) != e.ps) begin
      n_bad++;
      $display("FAIL %s smp=%0d: actual mode=%0d pref=%0d gate=%0d/%0d ovr=%0d/%0d expected mode=%0d pref=%0d gate=%0d ovr=%0d/%0d",
               tag, n_smp, mode, p_ref, inv_gate, dcdc_gate, ps_ovr_valid, ps_ovr,
               e.mode, e.pref, e.gate, e.psv, e.ps);
    end
  endtask

  // driver: one strobe, expectation pushed to the scoreboard
  task automatic send(input int v);
    exp_t e;
    @(negedge clk);
    v_smp = 12'(v); smp_valid = 1'b1;
    model_step(v);
    e.mode = m_mode; e.pref = m_pref; e.gate = m_gate;
    e.psv = (m_mode == 1 || m_mode == 3) ? 1 : 0;
    e.ps = (m_mode == 1) ? 9830 : 0;
    e.tag = tag_now;
    sb_q.push_back(e);
    n_smp++;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  int ph = 0;
  task automatic run(input int amp, input int cnt, input string tag, input bit glitch);
    bit glitched = 0;
    tag_now = tag;
    for (int i = 0; i < cnt; i++) begin
      int v = $rtoi(real'(amp) * $sin(2.0 * 3.14159265358979 * real'(ph % 340) / 340.0));
      if (glitch && !glitched && (ph % 340) == 85) begin v = 0; glitched = 1; end
      send(v);
      ph++;
    end
  endtask

  // monitor: pop and compare after each strobe edge, then once more between strobes
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (smp_valid) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R10: actual strobe with empty scoreboard expected none");
        end else begin
          e = sb_q.pop_front();
          check(e, e.tag);
          @(negedge clk);
          check(e, "R10");
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL R10: watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    for (int i = 0; i < 85; i++) dq.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r.mode = 3; r.pref = 0; r.gate = 0; r.psv = 1; r.ps = 0; r.tag = "R9";
    check(r, "R9");                       // R9 reset state
    p_cmd = 13'd7000;
    run(574, 800, "R7", 0);               // start-up: good cycle, ramp to latched 6000
    run(574, 100, "R3", 0);               // saturated command
    p_cmd = 13'd5000;
    run(574, 100, "R3", 0);
    run(231, 200, "R1", 0);               // just above the 40 % code
    run(574, 340, "R2", 1);               // single-strobe dropout ignored
    run(150, 1020, "R4", 0);              // moderate dip: hold window
    run(150, 300, "R5", 0);               // then peak-scaled reference
    run(574, 300, "R8", 0);               // ramp back to 5000
    run(40, 200, "R6", 0);                // severe dip from normal
    run(574, 700, "R7", 0);
    run(0, 200, "R6", 0);
    run(172, 1200, "R7", 0);              // severe to moderate: gates back into hold
    run(574, 300, "R8", 0);
    run(150, 200, "R4", 0);
    run(0, 100, "R6", 0);                 // severe takes priority over hold
    run(574, 700, "R8", 0);
    repeat (6) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule